// File: doc/BRIEF.md
# Serial Line Break and Idle Monitor

This block watches a single asynchronous serial line, one sample per clock, and reports two long-duration line conditions. A break is a low level that lasts at least one full character time. Idle is a high level that lasts one full character time. The character time in samples is derived from the configured word shape: one start bit, the data bits, an optional parity bit and one or two stop bits, multiplied by the bit width in samples. A polarity control flips the line before any of this is evaluated.

Each detection is reported as a one-clock pulse together with the measured run length. The break pulse is meant to drive the resynchronisation input of a companion character receiver, so that the receiver returns to hunting for a start bit. That receiver feeds back an end-of-character strobe in the sample where its character is expected to end, and that strobe restarts the idle measurement from that point. Idle pulses repeat for every further character time of steady high.

The controller has four states. `LW_BOOT` is entered at reset and left on the first sample, to `LW_HIGH` if the sample is high and to `LW_LOW_BLIND` if it is low. `LW_LOW_BLIND` is a low run whose start was never seen; a rise moves it to `LW_HIGH` with no break. In `LW_HIGH` a low sample is a fall and moves to `LW_LOW_TIMED`. In `LW_LOW_TIMED` a rise returns to `LW_HIGH` and may declare a break.

Top module: `uart_line_watch`

## Requirements
- R1: While reset is asserted, `brk_pulse` and `idle_pulse` are 0 and `brk_len` and `idle_len` are 0.
- R2: The character time is `(2 + data_bits + parity_en + stop_two) * bit_width` samples, and it is used as the threshold for both the break test and the idle test. A `bit_width` of 0 disables both detections.
- R3: Every test is applied to the corrected level `line_in XOR invert`. "High" and "low" in the other requirements refer to this corrected level.
- R4: A rise ends a low run. The rise triggers a break when the run began at a fall seen after reset and lasted at least the character time. In that case `brk_pulse` is 1 in the cycle after the rising sample, and `brk_len` reports the number of low samples. A low run already present when reset ends never produces a break.
- R5: The high count is 1 on a rising sample, or on the first sample after reset if that sample is high. On each later high sample the count advances by one. When it reaches the character time, `idle_pulse` is 1 in the next cycle, `idle_len` reports the count, and the count restarts from 0 at that sample. A long high run therefore yields repeated idle pulses.
- R6: `frame_end` on a high sample sets the high count to 0 at that sample, and no idle pulse results from that sample. `frame_end` on a low sample has no effect.
- R7: Any low sample cancels the idle measurement. No idle pulse follows a low sample.
- R8: The low and high counts saturate at 2^CNT_W-1 and never wrap.
- R9: Each pulse lasts exactly one clock. The two pulses are never 1 in the same cycle. `brk_len` and `idle_len` hold their last value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw serial line |
| invert | input | 1 | 1 flips the line polarity |
| data_bits | input | DB_W | Data bits per character |
| parity_en | input | 1 | 1 when a parity bit is present |
| stop_two | input | 1 | 0 = one stop bit, 1 = two stop bits |
| bit_width | input | BITW_W | Samples per bit (0 disables detection) |
| frame_end | input | 1 | End-of-character strobe from the receiver |
| brk_pulse | output | 1 | Break detected (one clock); also the receiver resync strobe |
| brk_len | output | CNT_W | Low-run length of the last break |
| idle_pulse | output | 1 | Idle character time elapsed (one clock) |
| idle_len | output | CNT_W | High count at the last idle pulse |

## Verification
The threshold is tested at exactly one sample below the character time and exactly at it, for two word shapes. A design with an off-by-one count, or with a wrong parity or stop term in the length, would fire on the wrong run or miss the right one.

Several cases target lost or false events:
- A low run present at reset, followed by a rise, must stay silent. A design that armed its break timer at reset would report a false break.
- A short low glitch inside a high run must restart the idle timing. A design that paused the count instead would emit an early idle.
- A mid-run `frame_end` must delay the next idle pulse.

The remaining cases cover the count limits and the disabled setting:
- A very long low run must report the saturated length rather than a wrapped small one.
- A zero bit width must produce no events at all.

// File: rtl/uart_lw_pkg.sv
package uart_lw_pkg;

    typedef enum logic [1:0] {
        LW_BOOT,
        LW_LOW_BLIND,
        LW_LOW_TIMED,
        LW_HIGH
    } lw_state_t;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_ZERO,
        CNT_ONE,
        CNT_INC
    } cnt_op_t;

endpackage

// File: rtl/lw_frame_len.sv
module lw_frame_len #(
    parameter int DB_W   = 4,
    parameter int BITW_W = 12,
    parameter int FL_W   = DB_W + 1 + BITW_W
) (
    input  logic [DB_W-1:0]   data_bits,
    input  logic              parity_en,
    input  logic              stop_two,
    input  logic [BITW_W-1:0] bit_width,
    output logic [FL_W-1:0]   frame_len
);
    localparam int FB_W = DB_W + 1;

    logic [FB_W-1:0] frame_bits;

    // start + first stop are always present; the other terms are optional
    always_comb begin
        frame_bits = FB_W'(2) + FB_W'(data_bits) + FB_W'(parity_en) + FB_W'(stop_two);
        frame_len  = FL_W'(frame_bits) * FL_W'(bit_width);
    end

    initial begin
        a_r2_width_ok: assert (DB_W >= 2 && FL_W >= FB_W + BITW_W)
            else $error("frame length width too small");
    end

endmodule

// File: rtl/lw_run_counter.sv
module lw_run_counter
    import uart_lw_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_op_t      op,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (op)
                CNT_HOLD: cnt <= cnt;
                CNT_ZERO: cnt <= '0;
                CNT_ONE:  cnt <= W'(1);
                CNT_INC:  cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
                default:  cnt <= cnt;
            endcase
        end
    end

    // R8: a full counter stays full when asked to count on
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_INC && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/lw_ctrl.sv
module lw_ctrl
    import uart_lw_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int FL_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             frame_end,
    input  logic [FL_W-1:0]  frame_len,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    output cnt_op_t          lo_op,
    output cnt_op_t          hi_op,
    output logic             brk_pulse,
    output logic [CNT_W-1:0] brk_len,
    output logic             idle_pulse,
    output logic [CNT_W-1:0] idle_len
);
    localparam int CW = (FL_W > CNT_W) ? FL_W : CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    lw_state_t        st_q, st_d;
    logic [CNT_W-1:0] hi_plus;
    logic [CW-1:0]    fl_x, lo_x, hi_plus_x;
    logic             detect_en;
    logic             brk_fire, idle_fire;
    cnt_op_t          rise_hi_op;

    always_comb begin
        hi_plus    = (hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + 1'b1;
        fl_x       = CW'(frame_len);
        lo_x       = CW'(lo_cnt);
        hi_plus_x  = CW'(hi_plus);
        detect_en  = (frame_len != '0);
        rise_hi_op = frame_end ? CNT_ZERO : CNT_ONE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LW_BOOT;
        else        st_q <= st_d;
    end

    // next state and counter commands
    always_comb begin
        st_d      = st_q;
        lo_op     = CNT_HOLD;
        hi_op     = CNT_HOLD;
        brk_fire  = 1'b0;
        idle_fire = 1'b0;
        unique case (st_q)
            LW_BOOT: begin
                if (lvl) begin
                    st_d  = LW_HIGH;
                    hi_op = rise_hi_op;
                end else begin
                    st_d  = LW_LOW_BLIND;
                end
            end
            LW_LOW_BLIND: begin
                if (lvl) begin
                    st_d  = LW_HIGH;
                    hi_op = rise_hi_op;
                end
            end
            LW_LOW_TIMED: begin
                if (lvl) begin
                    st_d     = LW_HIGH;
                    hi_op    = rise_hi_op;
                    brk_fire = detect_en && (lo_x >= fl_x);
                end else begin
                    lo_op = CNT_INC;
                end
            end
            LW_HIGH: begin
                if (!lvl) begin
                    st_d  = LW_LOW_TIMED;
                    lo_op = CNT_ONE;
                end else if (frame_end) begin
                    hi_op = CNT_ZERO;
                end else if (detect_en && (hi_plus_x >= fl_x)) begin
                    idle_fire = 1'b1;
                    hi_op     = CNT_ZERO;
                end else begin
                    hi_op = CNT_INC;
                end
            end
            default: st_d = LW_BOOT;
        endcase
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_pulse  <= 1'b0;
            brk_len    <= '0;
            idle_pulse <= 1'b0;
            idle_len   <= '0;
        end else begin
            brk_pulse  <= brk_fire;
            idle_pulse <= idle_fire;
            if (brk_fire)  brk_len  <= lo_cnt;
            if (idle_fire) idle_len <= hi_plus;
        end
    end

    // R9: never both events in one cycle
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_pulse && idle_pulse));

    // R9: break is a single-cycle strobe
    a_r9_brk_single: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    // R9: idle is a single-cycle strobe
    a_r9_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |=> !idle_pulse);

    // R4: a reported break is at least one character time long
    a_r4_brk_min: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> (CW'(brk_len) >= fl_x));

    // R4: a low run whose start was not seen cannot end in a break
    a_r4_blind_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LW_LOW_BLIND) |=> !brk_pulse);

    // R5: an idle report covers at least one character time
    a_r5_idle_min: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |-> (CW'(idle_len) >= fl_x));

    // R7: a low sample is never followed by an idle report
    a_r7_low_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl |=> !idle_pulse);

    // R6: a seeding strobe on a high sample suppresses idle for that sample
    a_r6_seed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && frame_end) |=> !idle_pulse);

endmodule

// File: rtl/uart_line_watch.sv
module uart_line_watch
    import uart_lw_pkg::*;
#(
    parameter int DB_W   = 4,
    parameter int BITW_W = 12,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              invert,
    input  logic [DB_W-1:0]   data_bits,
    input  logic              parity_en,
    input  logic              stop_two,
    input  logic [BITW_W-1:0] bit_width,
    input  logic              frame_end,
    output logic              brk_pulse,
    output logic [CNT_W-1:0]  brk_len,
    output logic              idle_pulse,
    output logic [CNT_W-1:0]  idle_len
);
    localparam int FL_W = DB_W + 1 + BITW_W;

    logic             lvl;
    logic [FL_W-1:0]  frame_len;
    logic [CNT_W-1:0] lo_cnt, hi_cnt;
    cnt_op_t          lo_op, hi_op;

    assign lvl = line_in ^ invert;

    lw_frame_len #(
        .DB_W   (DB_W),
        .BITW_W (BITW_W),
        .FL_W   (FL_W)
    ) u_len (
        .data_bits (data_bits),
        .parity_en (parity_en),
        .stop_two  (stop_two),
        .bit_width (bit_width),
        .frame_len (frame_len)
    );

    lw_run_counter #(.W(CNT_W)) u_lo_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (lo_op),
        .cnt   (lo_cnt)
    );

    lw_run_counter #(.W(CNT_W)) u_hi_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (hi_op),
        .cnt   (hi_cnt)
    );

    lw_ctrl #(
        .CNT_W (CNT_W),
        .FL_W  (FL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .frame_end  (frame_end),
        .frame_len  (frame_len),
        .lo_cnt     (lo_cnt),
        .hi_cnt     (hi_cnt),
        .lo_op      (lo_op),
        .hi_op      (hi_op),
        .brk_pulse  (brk_pulse),
        .brk_len    (brk_len),
        .idle_pulse (idle_pulse),
        .idle_len   (idle_len)
    );

endmodule

// File: tb/uart_line_watch_test.sv
module uart_line_watch_test;
    localparam int DB_W   = 4;
    localparam int BITW_W = 8;
    localparam int CNT_W  = 10;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_in = 1'b1;
    logic              invert = 1'b0;
    logic [DB_W-1:0]   data_bits = '0;
    logic              parity_en = 1'b0;
    logic              stop_two = 1'b0;
    logic [BITW_W-1:0] bit_width = '0;
    logic              frame_end = 1'b0;
    logic              brk_pulse, idle_pulse;
    logic [CNT_W-1:0]  brk_len, idle_len;

    always #5 clk = ~clk;

    uart_line_watch #(.DB_W(DB_W), .BITW_W(BITW_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(invert),
        .data_bits(data_bits), .parity_en(parity_en), .stop_two(stop_two),
        .bit_width(bit_width), .frame_end(frame_end),
        .brk_pulse(brk_pulse), .brk_len(brk_len),
        .idle_pulse(idle_pulse), .idle_len(idle_len)
    );

    int    checks = 0, errors = 0;
    int    n, fall_n, origin, prev, fl;
    int    exp_b, exp_i, exp_blen, exp_ilen;
    int    brk_seen, idle_seen;
    bit    done = 1'b0;
    string req = "R1";

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic compare();
        chk({req, " R9"}, "brk_pulse", int'(brk_pulse), exp_b);
        chk({req, " R9"}, "idle_pulse", int'(idle_pulse), exp_i);
        chk({req, " R9"}, "brk_len", int'(brk_len), exp_blen);
        chk({req, " R9"}, "idle_len", int'(idle_len), exp_ilen);
        if (brk_pulse === 1'b1) brk_seen++;
        if (idle_pulse === 1'b1) idle_seen++;
    endtask

    // behavioural reference: positions of the last fall and of the idle origin
    task automatic model(int v, int fe);
        int c;
        exp_b = 0;
        exp_i = 0;
        if (prev < 0) begin
            if (v == 1) origin = (fe == 1) ? n : n - 1;
            fall_n = -1;
        end else if (prev == 0) begin
            if (v == 1) begin
                if (fall_n >= 0) begin
                    c = (n - fall_n > MAXC) ? MAXC : n - fall_n;
                    if (fl > 0 && c >= fl) begin
                        exp_b = 1;
                        exp_blen = c;
                    end
                end
                fall_n = -1;
                origin = (fe == 1) ? n : n - 1;
            end
        end else begin
            if (v == 0) begin
                fall_n = n;
                origin = -1;
            end else if (fe == 1) begin
                origin = n;
            end else begin
                c = (n - origin > MAXC) ? MAXC : n - origin;
                if (fl > 0 && c >= fl) begin
                    exp_i = 1;
                    exp_ilen = c;
                    origin = n;
                end
            end
        end
        prev = v;
        n++;
    endtask

    task automatic step(int v, int fe);
        compare();
        line_in   = logic'(v[0] ^ invert);
        frame_end = logic'(fe[0]);
        model(v, fe);
        @(negedge clk);
    endtask

    task automatic hold(int v, int cnt);
        for (int k = 0; k < cnt; k++) step(v, 0);
    endtask

    task automatic do_reset(int db, int par, int st2, int bw, int iv);
        @(negedge clk);
        rst_n     = 1'b0;
        frame_end = 1'b0;
        data_bits = DB_W'(db);
        parity_en = logic'(par[0]);
        stop_two  = logic'(st2[0]);
        bit_width = BITW_W'(bw);
        invert    = logic'(iv[0]);
        repeat (3) @(negedge clk);
        chk("R1", "reset brk_pulse", int'(brk_pulse), 0);
        chk("R1", "reset idle_pulse", int'(idle_pulse), 0);
        chk("R1", "reset brk_len", int'(brk_len), 0);
        chk("R1", "reset idle_len", int'(idle_len), 0);
        fl = (2 + db + par + st2) * bw;
        n = 0; fall_n = -1; origin = -1; prev = -1;
        exp_b = 0; exp_i = 0; exp_blen = 0; exp_ilen = 0;
        brk_seen = 0; idle_seen = 0;
        rst_n = 1'b1;
    endtask

    task automatic clear_seen();
        brk_seen = 0;
        idle_seen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R5: steady high after reset, 8N1 at 4 samples per bit (40)
        req = "R5";
        do_reset(8, 0, 0, 4, 0);
        hold(1, 130);
        chk("R5", "repeated idle count", idle_seen, 3);
        chk("R5", "idle_len", int'(idle_len), 40);

        // R4: threshold below, at and above the character time
        req = "R4";
        clear_seen();
        hold(0, 39); hold(1, 5);
        hold(0, 40); hold(1, 5);
        hold(0, 50); hold(1, 5);
        chk("R4", "break count", brk_seen, 2);
        chk("R4", "last brk_len", int'(brk_len), 50);

        // R2: 7 data, parity, two stops, 3 samples per bit -> 33
        req = "R2";
        do_reset(7, 1, 1, 3, 0);
        hold(1, 5); hold(0, 32); hold(1, 5);
        chk("R2", "no break at 32", brk_seen, 0);
        hold(0, 33); hold(1, 5);
        chk("R2", "break at 33", brk_seen, 1);
        chk("R2", "brk_len", int'(brk_len), 33);

        // R3: inverted polarity, corrected low = raw high
        req = "R3";
        do_reset(8, 0, 0, 4, 1);
        hold(1, 5); hold(0, 45); hold(1, 3);
        chk("R3", "inverted break count", brk_seen, 1);
        chk("R3", "inverted brk_len", int'(brk_len), 45);

        // R6: end-of-character strobe reseeds idle timing
        req = "R6";
        do_reset(8, 0, 0, 4, 0);
        hold(1, 30); step(1, 1); hold(1, 39);
        chk("R6", "idle delayed by seed", idle_seen, 0);
        hold(1, 2);
        chk("R6", "idle after seed", idle_seen, 1);

        // R4: low run present at reset never breaks; R6 strobe on low ignored
        req = "R4";
        do_reset(8, 0, 0, 4, 0);
        hold(0, 60); hold(1, 5);
        chk("R4", "blind low no break", brk_seen, 0);
        req = "R6";
        hold(0, 10); step(0, 1); hold(0, 9); hold(1, 39);
        chk("R6", "strobe on low ignored", idle_seen, 0);
        hold(1, 2);
        chk("R6", "idle after low strobe", idle_seen, 1);

        // R7: a short low glitch restarts idle timing
        req = "R7";
        do_reset(8, 0, 0, 4, 0);
        hold(1, 30); hold(0, 3); hold(1, 39);
        chk("R7", "glitch cancels idle", idle_seen, 0);
        chk("R7", "glitch no break", brk_seen, 0);
        hold(1, 2);
        chk("R7", "idle after glitch", idle_seen, 1);

        // R8: saturation of a very long low run
        req = "R8";
        do_reset(8, 0, 0, 4, 0);
        hold(1, 2); hold(0, 1500); hold(1, 3);
        chk("R8", "saturated break count", brk_seen, 1);
        chk("R8", "saturated brk_len", int'(brk_len), MAXC);

        // R2: zero bit width disables both detections
        req = "R2";
        do_reset(8, 0, 0, 0, 0);
        hold(1, 100); hold(0, 100); hold(1, 100);
        chk("R2", "disabled breaks", brk_seen, 0);
        chk("R2", "disabled idles", idle_seen, 0);

        compare();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule